// File: doc/BRIEF.md
# Transmit-Path Supervisor for a Single-Wire Bus

This block decides whether a node may drive a shared single-wire bus. It compares the data the node wants to send against the level it reads back from the wire, and it also watches how long the transmit data stays low. When either check fails, it withdraws transmit permission. Permission returns only after a quiet period in which both the transmit data and the bus sit high.

A bidirectional status pin is modelled as two pairs of signals: an input value with a "driven externally" flag, and an output value with an output-enable. When the pin is left free, the block reports the path state on it: 0 means transmit is enabled and 1 means it is disabled. When something outside drives the pin, its level overrides both checks. A low level forces transmit on and a high level forces it off. The received bus level is always passed through, whatever the transmit state.

All inputs pass through a two-flop synchronizer. Every time window is a parameter counted in clock cycles. Throughout this brief, a "cycle" of a condition means one synchronized clock cycle in which that condition holds.

Top module: `txsup_top`

## Requirements
- R1: After reset the supervised path is disabled: `tx_en_o` is 0, `pin_val_o` is 1 and `pin_oe_o` is 1.
- R2: While the path is enabled, a mismatch between the transmit data and the bus level that persists for `MISMATCH_CYC` consecutive cycles disables the path. A mismatch lasting one cycle fewer does not disable it.
- R3: While the path is enabled, transmit data that stays low for `LOW_CYC` accumulated cycles disables the path. A shorter low run does not disable it.
- R4: A transmit-high run of at least `RECOVER_CYC` cycles clears the accumulated low time. A shorter high run leaves it intact, and the count continues when the data falls again.
- R5: A disabled path becomes enabled exactly `ENABLE_CYC` cycles after the transmit data and the bus both became high, counting from when both inputs are high at the pins, plus 2 cycles of synchronizer latency. Any break in that condition restarts the count.
- R6: When `pin_driven_i` is 1 and `pin_val_i` is 0, `tx_en_o` is 1 regardless of the supervision state.
- R7: When `pin_driven_i` is 1 and `pin_val_i` is 1, `tx_en_o` is 0 regardless of the supervision state.
- R8: When the pin is not driven externally, `pin_oe_o` is 1 and `pin_val_o` equals the inverse of `tx_en_o`. When the pin is driven externally, `pin_oe_o` is 0.
- R9: `rxd_o` equals `bus_i` delayed by two clock cycles, independent of the transmit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Transmit data from the protocol controller |
| bus_i | input | 1 | Level read back from the bus wire |
| pin_val_i | input | 1 | Level seen on the status pin when driven externally |
| pin_driven_i | input | 1 | 1 when something outside drives the status pin |
| tx_en_o | output | 1 | Transmit path enable |
| pin_val_o | output | 1 | Status value the block drives: 0 enabled, 1 disabled |
| pin_oe_o | output | 1 | Output enable for the status pin |
| rxd_o | output | 1 | Synchronized received bus level |

## Verification
Four properties are checked on every cycle. Each counter stays within its limit. A completed mismatch or low-time run always turns the path off on the next edge. The path never turns on without a completed enable window. The receive output and the override results match the pins two cycles earlier. Other behaviour depends on exact window lengths, and only the bench scenarios show it: the one-cycle-short versus full-length boundaries, the way a short high pulse leaves the low-time accumulation intact, and the restart of the enable window after a break. The bench sweeps mismatch lengths, low-run lengths, recovery pulse widths and receive patterns across these edges.

// File: rtl/txsup_pkg.sv
// Package: shared types for the transmit-path supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package txsup_pkg;
    typedef enum logic {
        PATH_OFF = 1'b0,
        PATH_ON  = 1'b1
    } path_state_e;
endpackage

// File: rtl/txsup_sync.sv
// Module: txsup_sync
// Two-flop synchronizer for a vector of independent single-bit inputs.
// Assumes: each bit is a quasi-static level; INIT gives the reset level per bit.
module txsup_sync #(
    parameter int          WIDTH = 4,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Two registers per bit, both loaded with the bit's idle level on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1_q[b] <= INIT[b];
                stage2_q[b] <= INIT[b];
            end else begin
                stage1_q[b] <= d_i[b];
                stage2_q[b] <= stage1_q[b];
            end
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/txsup_run_counter.sv
// Module: txsup_run_counter
// Saturating run-length counter. It counts cycles with inc_i high and returns
// to zero on clr_i. hit_o flags the cycle whose edge completes LIMIT counts.
// Assumes: LIMIT >= 1; clr_i takes priority over inc_i.
module txsup_run_counter #(
    parameter int LIMIT = 4,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic clr_i,
    output logic hit_o
);
    logic [W-1:0] cnt_q;

    // Advance, clear or hold the run count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != W'(LIMIT)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // The present edge completes the run.
    assign hit_o = inc_i && !clr_i && (cnt_q == W'(LIMIT - 1));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));

    // R3
    hit_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && rst_n) |=> (cnt_q == W'(LIMIT)));
endmodule

// File: rtl/txsup_path_fsm.sv
// Module: txsup_path_fsm
// Holds the supervised path state. A fault turns an enabled path off. A
// completed enable window turns a disabled path on.
// Assumes: fault and window flags are single-cycle pulses from run counters.
module txsup_path_fsm
    import txsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic window_i,
    output logic on_o
);
    path_state_e state_q;

    // Path state register: starts off and moves on fault or window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PATH_OFF;
        end else begin
            case (state_q)
                PATH_ON:  if (fault_i)  state_q <= PATH_OFF;
                default:  if (window_i) state_q <= PATH_ON;
            endcase
        end
    end

    assign on_o = (state_q == PATH_ON);

    // R2 R3
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_o && fault_i) |=> !on_o);

    // R5
    window_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_o && !window_i) |=> !on_o);

    // R5
    stay_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_o && !fault_i) |=> on_o);
endmodule

// File: rtl/txsup_top.sv
// Module: txsup_top
// Transmit-path supervisor. It runs the mismatch and constant-low checks,
// applies the shared re-enable window and the status-pin override, and
// passes the received level through.
// Assumes: the bus idles high; every window parameter is >= 1 cycle.
module txsup_top #(
    parameter int MISMATCH_CYC = 3,
    parameter int LOW_CYC      = 8,
    parameter int RECOVER_CYC  = 3,
    parameter int ENABLE_CYC   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txd_i,
    input  logic bus_i,
    input  logic pin_val_i,
    input  logic pin_driven_i,
    output logic tx_en_o,
    output logic pin_val_o,
    output logic pin_oe_o,
    output logic rxd_o
);
    localparam int          SYNC_W    = 4;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b0111;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn;
    logic tx_s, bus_s, pval_s, pdrv_s;
    logic mismatch, both_high;
    logic mm_hit, rec_hit, low_hit, win_hit;
    logic sup_on;

    assign raw_in = {pin_driven_i, pin_val_i, bus_i, txd_i};

    txsup_sync #(.WIDTH(SYNC_W), .INIT(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn)
    );

    assign tx_s   = syn[0];
    assign bus_s  = syn[1];
    assign pval_s = syn[2];
    assign pdrv_s = syn[3];

    assign mismatch  = tx_s ^ bus_s;
    assign both_high = tx_s & bus_s;

    // Consecutive mismatch cycles.
    txsup_run_counter #(.LIMIT(MISMATCH_CYC)) u_mismatch (
        .clk(clk), .rst_n(rst_n), .inc_i(mismatch), .clr_i(!mismatch),
        .hit_o(mm_hit)
    );

    // Consecutive transmit-high cycles, used to clear the low accumulation.
    txsup_run_counter #(.LIMIT(RECOVER_CYC)) u_recover (
        .clk(clk), .rst_n(rst_n), .inc_i(tx_s), .clr_i(!tx_s),
        .hit_o(rec_hit)
    );

    // Accumulated transmit-low cycles; held through short high pulses.
    txsup_run_counter #(.LIMIT(LOW_CYC)) u_low (
        .clk(clk), .rst_n(rst_n), .inc_i(!tx_s), .clr_i(rec_hit || !sup_on),
        .hit_o(low_hit)
    );

    // Consecutive cycles with transmit data and bus both high.
    txsup_run_counter #(.LIMIT(ENABLE_CYC)) u_window (
        .clk(clk), .rst_n(rst_n), .inc_i(both_high), .clr_i(!both_high),
        .hit_o(win_hit)
    );

    txsup_path_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fault_i(mm_hit || low_hit),
        .window_i(win_hit), .on_o(sup_on)
    );

    // The status pin, when driven, wins over supervision.
    always_comb begin
        tx_en_o = pdrv_s ? !pval_s : sup_on;
    end

    assign pin_oe_o  = !pdrv_s;
    assign pin_val_o = !tx_en_o;
    assign rxd_o     = bus_s;

    // R9
    rx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (rxd_o == $past(bus_i, 2)));

    // R6
    force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(pin_driven_i, 2)
         && !$past(pin_val_i, 2)) |-> tx_en_o);

    // R7
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(pin_driven_i, 2)
         && $past(pin_val_i, 2)) |-> !tx_en_o);
endmodule

// File: tb/tb_txsup_top.sv
module tb_txsup_top;
    localparam int CLK_PERIOD = 10;
    localparam int MM  = 3;
    localparam int LOW = 8;
    localparam int REC = 3;
    localparam int ENA = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txd = 1'b1, bus = 1'b1, pval = 1'b0, pdrv = 1'b0;
    logic tx_en, pin_val, pin_oe, rxd;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    txsup_top #(.MISMATCH_CYC(MM), .LOW_CYC(LOW), .RECOVER_CYC(REC),
                .ENABLE_CYC(ENA)) dut (
        .clk(clk), .rst_n(rst_n), .txd_i(txd), .bus_i(bus),
        .pin_val_i(pval), .pin_driven_i(pdrv), .tx_en_o(tx_en),
        .pin_val_o(pin_val), .pin_oe_o(pin_oe), .rxd_o(rxd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // R8: status pin consistency while the pin is free
    task automatic chk_status();
        chk("R8 oe", pin_oe, 1'b1);
        chk("R8 val", pin_val, !tx_en);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle_on();
        txd = 1'b1; bus = 1'b1;
        step(ENA + 4);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1
        chk("R1 tx_en", tx_en, 1'b0);
        chk("R1 pin_val", pin_val, 1'b1);
        chk("R1 pin_oe", pin_oe, 1'b1);

        // R5: enable window timing from reset
        settle_on();
        chk("R5 on after reset", tx_en, 1'b1);

        // R2: mismatch length sweep
        for (int len = 1; len <= MM + 2; len++) begin
            bus = 1'b0;
            step(len);
            bus = 1'b1;
            step(3);
            chk("R2 mismatch", tx_en, (len >= MM) ? 1'b0 : 1'b1);
            chk_status();
            settle_on();
        end

        // R3: low run sweep, bus follows data
        for (int len = 1; len <= LOW + 3; len++) begin
            txd = 1'b0; bus = 1'b0;
            step(len);
            txd = 1'b1; bus = 1'b1;
            step(3);
            chk("R3 low run", tx_en, (len >= LOW) ? 1'b0 : 1'b1);
            chk_status();
            settle_on();
        end

        // R4: recovery pulse width sweep (5 low + pulse + 4 low)
        for (int h = 1; h <= REC + 2; h++) begin
            txd = 1'b0; bus = 1'b0; step(5);
            txd = 1'b1; bus = 1'b1; step(h);
            txd = 1'b0; bus = 1'b0; step(4);
            txd = 1'b1; bus = 1'b1; step(3);
            chk("R4 recovery", tx_en, (h >= REC) ? 1'b1 : 1'b0);
            settle_on();
        end

        // R5: exact enable timing after a mismatch disable
        bus = 1'b0; step(MM + 1);
        bus = 1'b1;
        step(ENA + 1);
        chk("R5 not yet", tx_en, 1'b0);
        step(1);
        chk("R5 window done", tx_en, 1'b1);

        // R5: a break restarts the window
        bus = 1'b0; step(MM + 1);
        bus = 1'b1; step(ENA - 1);
        bus = 1'b0; step(1);
        bus = 1'b1;
        step(ENA + 1);
        chk("R5 restart early", tx_en, 1'b0);
        step(1);
        chk("R5 restart done", tx_en, 1'b1);

        // R7: external 1 forces off while supervision is on
        pdrv = 1'b1; pval = 1'b1; step(3);
        chk("R7 forced off", tx_en, 1'b0);
        chk("R8 oe driven", pin_oe, 1'b0);
        pdrv = 1'b0; step(3);
        chk("R7 released", tx_en, 1'b1);

        // R6: external 0 forces on while supervision is off
        bus = 1'b0; step(MM + 2);
        chk("R6 precondition", tx_en, 1'b0);
        pdrv = 1'b1; pval = 1'b0; step(3);
        chk("R6 forced on", tx_en, 1'b1);
        pdrv = 1'b0; step(3);
        chk("R6 released", tx_en, 1'b0);
        chk_status();

        // R9: receive pass-through with transmit toggling on and off
        begin
            logic h1, h2;
            h1 = bus; h2 = bus;
            for (int i = 0; i < 40; i++) begin
                if (i >= 2) chk("R9 rxd", rxd, h2);
                h2 = h1;
                bus = ((i * 37) >> 2) & 1;
                h1 = bus;
                step(1);
            end
        end

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule